// File: doc/BRIEF.md
# Port Error Capture With Mask

This block keeps the error record for one accelerator port. Error event lines arrive as a 64-bit vector. Each line that is not masked sets a sticky bit in the error register. The block also keeps a separate first-error record. This record takes a snapshot of the unmasked events of the cycle in which it was empty, so software can tell which fault came first when several bits are set. A mask register stops capture bit by bit. Software sets every mask bit while it clears the record and writes zero afterwards, and capture then resumes.

Software reaches four word registers over a small request/response register bus:

| Address | Register | Access |
|---|---|---|
| 0 | error | write-1-to-clear |
| 1 | first-error | write-1-to-clear |
| 2 | mask | read/write |
| 3 | status | read-only, port power-state field in its low bits |

The bus has two channels:
- **Request channel.** A request moves when `req_valid` and `req_ready` are both high at a clock edge.
- **Response channel.** Every request, read or write, gets exactly one response in the following cycle. A write response carries zero data.
- **Back-pressure.** The response slot holds one entry. `req_ready` is low while that slot is full and `rsp_ready` is low. The held response stays stable until it is taken.

A level output reports whether any error bit is set.

Top module: `pec_port_err`

## Requirements
- R1: After reset, the error, first-error and mask registers read zero, `err_present` is low, `rsp_valid` is low and `req_ready` is high.
- R2: An event bit that is high at a clock edge, with its mask bit at 0, sets the matching error bit at that edge.
- R3: Error bits are sticky: a set bit stays set until software clears it, whatever the event lines do.
- R4: A mask bit at 1 stops its event from reaching both the error and first-error registers. A mask of all ones blocks every event. Events are captured again once the mask is written back to 0. A mask write takes effect from the edge after the write is accepted.
- R5: A write to address 0 clears every error bit whose data bit is 1 and leaves bits whose data bit is 0 unchanged. Writing back the value just read therefore clears exactly what was read.
- R6: At any edge where the first-error register is zero after that edge's clear has been applied, it loads the unmasked event bits of that cycle. While it is nonzero and not written, it holds.
- R7: A write to address 1 clears the first-error bits whose data bit is 1. If unmasked events arrive in the same cycle and the register is left empty by the clear, it loads those events.
- R8: When an event and a clear hit the same error bit in the same cycle, the bit ends set.
- R9: `err_present` is high exactly when at least one error bit is set, from the edge at which the bit is set.
- R10: A read of address 3 returns the `pwr_state` input in its low `PWR_W` bits and zeros above. Writes to address 3 change nothing. A read of address 2 returns the last value written to the mask.
- R11: Each accepted request produces exactly one response, in order, in the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_valid` and `rsp_rdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Word address (0 error, 1 first-error, 2 mask, 3 status) |
| req_wdata | input | ERR_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | ERR_W | Read data (zero for writes) |
| err_ev | input | ERR_W | Error event lines, one per error bit |
| pwr_state | input | PWR_W | Port power-state code shown in the status register |
| err_present | output | 1 | OR of all error register bits |

## Verification
Capture of a new event and a software clear can land on the same error bit, or on the first-error record, in the same cycle. The bench provokes both cases by raising the event line in the same cycle that a clear write is accepted. For the error register, a later read must still show the bit set. For the first-error record, a later read must show the new event in place of the cleared snapshot. The bench also holds the response back to test that the request channel stalls and the held data stays stable.

// File: rtl/pec_pkg.sv
package pec_pkg;
  // Word addresses of the register bus; software decodes by this map.
  localparam int ADDR_W = 2;
  localparam int NREG   = 1 << ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ERR   = 2'd0,
    SEL_FIRST = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pec_bus_port.sv
module pec_bus_port
  import pec_pkg::*;
#(
  parameter int W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [W-1:0]      req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [W-1:0]      rsp_rdata,
  input  logic [W-1:0]      rd_err,
  input  logic [W-1:0]      rd_first,
  input  logic [W-1:0]      rd_mask,
  input  logic [W-1:0]      rd_stat,
  output logic [NREG-1:0]   wr_sel,
  output logic [W-1:0]      wr_data
);
  logic         accept;
  logic [W-1:0] rd_word;

  // Single response slot: a new request may enter when the slot is empty
  // or is being emptied in this same cycle.
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_data   = req_wdata;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_sel[i] = accept && req_write && (req_addr == ADDR_W'(i));
  end

  always_comb begin
    unique case (reg_sel_e'(req_addr))
      SEL_ERR:   rd_word = rd_err;
      SEL_FIRST: rd_word = rd_first;
      SEL_MASK:  rd_word = rd_mask;
      default:   rd_word = rd_stat;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pec_mask_reg.sv
module pec_mask_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end
endmodule

// File: rtl/pec_err_bank.sv
module pec_err_bank #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] err_ev,
  input  logic [W-1:0] mask_q,
  input  logic         err_clr_en,
  input  logic         first_clr_en,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] err_q,
  output logic [W-1:0] first_q
);
  logic [W-1:0] cap;
  logic [W-1:0] err_clr;
  logic [W-1:0] err_d;
  logic [W-1:0] first_kept;
  logic [W-1:0] first_d;

  assign cap = err_ev & ~mask_q;

  // Per-bit clear strobe, then set-dominant update so a fresh event survives
  // a clear landing in the same cycle.
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign err_clr[b] = err_clr_en && clr_data[b];
    assign err_d[b]   = cap[b] || (err_q[b] && !err_clr[b]);
  end

  always_comb begin
    first_kept = first_clr_en ? (first_q & ~clr_data) : first_q;
    first_d    = (first_kept == '0) ? cap : first_kept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= '0;
      first_q <= '0;
    end else begin
      err_q   <= err_d;
      first_q <= first_d;
    end
  end
endmodule

// File: rtl/pec_port_err.sv
module pec_port_err
  import pec_pkg::*;
#(
  parameter int ERR_W = 64,
  parameter int PWR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ERR_W-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ERR_W-1:0]  rsp_rdata,
  input  logic [ERR_W-1:0]  err_ev,
  input  logic [PWR_W-1:0]  pwr_state,
  output logic              err_present
);
  logic [NREG-1:0]  wr_sel;
  logic [ERR_W-1:0] wr_data;
  logic [ERR_W-1:0] err_q;
  logic [ERR_W-1:0] first_q;
  logic [ERR_W-1:0] mask_q;
  logic [ERR_W-1:0] stat_word;

  assign stat_word = ERR_W'(pwr_state);

  pec_bus_port #(.W(ERR_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rd_err    (err_q),
    .rd_first  (first_q),
    .rd_mask   (mask_q),
    .rd_stat   (stat_word),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data)
  );

  pec_mask_reg #(.W(ERR_W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_sel[SEL_MASK]),
    .wr_data (wr_data),
    .mask_q  (mask_q)
  );

  pec_err_bank #(.W(ERR_W)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_ev       (err_ev),
    .mask_q       (mask_q),
    .err_clr_en   (wr_sel[SEL_ERR]),
    .first_clr_en (wr_sel[SEL_FIRST]),
    .clr_data     (wr_data),
    .err_q        (err_q),
    .first_q      (first_q)
  );

  assign err_present = |err_q;
endmodule

// File: rtl/pec_port_err_chk.sv
module pec_port_err_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_ready,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_rdata,
  input logic [W-1:0] err_ev,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] err_q,
  input logic [W-1:0] first_q,
  input logic [3:0]   wr_sel,
  input logic         err_present
);
  logic [W-1:0] cap;
  assign cap = err_ev & ~mask_q;

  // R3: without a clear write no error bit falls
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel[0] |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R4: with nothing unmasked and no clear, the error register is frozen
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cap == '0 && !wr_sel[0]) |=> $stable(err_q));

  // R8: every unmasked event is set on the next cycle, clear or not
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & $past(cap)) == $past(cap)));

  // R6: a nonzero first-error record holds unless written
  a_r6_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q != '0 && !wr_sel[1]) |=> $stable(first_q));

  // R9: the present flag only rises after an unmasked event
  a_r9_present_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_present) |-> $past(cap != '0));

  // R11: a stalled response holds and blocks new requests
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind pec_port_err pec_port_err_chk #(.W(ERR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .err_ev      (err_ev),
  .mask_q      (mask_q),
  .err_q       (err_q),
  .first_q     (first_q),
  .wr_sel      (wr_sel),
  .err_present (err_present)
);

// File: tb/tb_pec_port_err.sv
module tb_pec_port_err;
  localparam int W = 64;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [1:0]   req_addr = '0;
  logic [W-1:0] req_wdata = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [W-1:0] rsp_rdata;
  logic [W-1:0] err_ev = '0;
  logic [P-1:0] pwr_state = 4'h6;
  logic         err_present;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [W-1:0] exp_q[$];
  bit           en_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  pec_port_err #(.ERR_W(W), .PWR_W(P)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .err_ev(err_ev), .pwr_state(pwr_state), .err_present(err_present)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issues one request, optionally with events in the same cycle,
  // and pushes the expected response into the scoreboard.
  task automatic bus(input bit wr, input logic [1:0] a, input logic [W-1:0] d,
                     input logic [W-1:0] ev, input bit en,
                     input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(exp); en_q.push_back(en); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; err_ev = ev;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; err_ev = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
    bus(1'b0, a, '0, '0, 1'b1, exp, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    bus(1'b1, a, d, '0, 1'b1, '0, "R11");
  endtask

  task automatic pulse(input logic [W-1:0] ev);
    @(negedge clk);
    err_ev = ev;
    @(negedge clk);
    err_ev = '0;
  endtask

  // Monitor: pops one expected item per response handshake.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected response", 1, 0);
      end else begin
        logic [W-1:0] e;
        bit           n;
        string        t;
        e = exp_q.pop_front(); n = en_q.pop_front(); t = tag_q.pop_front();
        if (n) chk(t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a;
    logic [W-1:0] held;
    a = (64'd1 << 3) | (64'd1 << 40);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 err_present", W'(err_present), '0);
    chk("R1 rsp_valid", W'(rsp_valid), '0);
    chk("R1 req_ready", W'(req_ready), W'(1));
    rst_n = 1'b1;
    rd(2'd0, '0, "R1 error");
    rd(2'd1, '0, "R1 first");
    rd(2'd2, '0, "R1 mask");
    rd(2'd3, 64'h6, "R10 status");
    // R2 / R6 / R9 first capture
    pulse(a);
    chk("R9 present after set", W'(err_present), W'(1));
    rd(2'd0, a, "R2 error set");
    rd(2'd1, a, "R6 first latched");
    // R3 sticky, first holds
    pulse(64'd1 << 5);
    rd(2'd0, a | (64'd1 << 5), "R3 sticky");
    rd(2'd1, a, "R6 first holds");
    // R5 partial write-1-to-clear
    wr(2'd0, 64'd1 << 3);
    rd(2'd0, (64'd1 << 40) | (64'd1 << 5), "R5 clear bit3");
    // R4 full mask blocks capture
    wr(2'd2, '1);
    pulse(64'd1 << 7);
    rd(2'd0, (64'd1 << 40) | (64'd1 << 5), "R4 full mask blocks");
    wr(2'd2, '0);
    rd(2'd2, '0, "R10 mask readback");
    pulse(64'd1 << 9);
    rd(2'd0, (64'd1 << 40) | (64'd1 << 5) | (64'd1 << 9), "R4 capture resumes");
    // R7 clear first, R4 partial mask, R6 reload
    wr(2'd1, a);
    rd(2'd1, '0, "R7 first cleared");
    wr(2'd2, 64'd1 << 11);
    pulse((64'd1 << 11) | (64'd1 << 12));
    rd(2'd0, (64'd1 << 40) | (64'd1 << 5) | (64'd1 << 9) | (64'd1 << 12), "R4 partial mask");
    rd(2'd1, 64'd1 << 12, "R6 first unmasked only");
    // R8 event and clear on same bit
    bus(1'b1, 2'd0, 64'd1 << 12, 64'd1 << 12, 1'b0, '0, "wr");
    rd(2'd0, (64'd1 << 40) | (64'd1 << 5) | (64'd1 << 9) | (64'd1 << 12), "R8 event wins");
    // R7 clear of first with concurrent event reloads
    bus(1'b1, 2'd1, 64'd1 << 12, 64'd1 << 20, 1'b0, '0, "wr");
    rd(2'd1, 64'd1 << 20, "R7 first reload");
    // R5 / R9 clear all
    wr(2'd0, '1);
    chk("R9 present cleared", W'(err_present), '0);
    rd(2'd0, '0, "R5 all cleared");
    wr(2'd1, 64'd1 << 20);
    rd(2'd1, '0, "R7 first empty");
    // R10 status ignores writes
    wr(2'd3, '1);
    rd(2'd3, 64'h6, "R10 status write ignored");
    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(2'd2, 64'd1 << 11, "R11 held response");
    chk("R11 rsp_valid held", W'(rsp_valid), W'(1));
    chk("R11 req_ready low", W'(req_ready), '0);
    held = rsp_rdata;
    repeat (3) @(negedge clk);
    chk("R11 still valid", W'(rsp_valid), W'(1));
    chk("R11 data stable", rsp_rdata, held);
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 queue drained", W'(exp_q.size()), '0);
    chk("R11 slot empty", W'(rsp_valid), '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule